// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is the output stage behind one pin of a small sum-of-products logic device. It ORs the product terms that the logic plane steers to its pin and passes the sum either straight through or through a D flip-flop, with a selectable output polarity. It also drives a tri-state pin model and a feedback line back to the logic plane.

Two select bits set the mode. `sel_comb_i` picks combinational (1) or registered (0) operation. `sel_high_i` picks active-high (1) or active-low (0) output. A dedicated product term enables the pin driver. Two global terms act on the flip-flop: one clears it at once, with no clock needed, and one sets it at the next clock edge. The feedback line carries the inverted flip-flop state in registered mode. In combinational mode it carries the level actually present on the pin, so a pin whose driver is disabled can serve as an input.

Top module: `out_macrocell`

## Requirements
- R1: With `sel_comb_i`=1 and `sel_high_i`=1, `pin_drive_o` equals the OR of all `N_TERMS` bits of `terms_i` in the same cycle. `N_TERMS` is a parameter from 8 to 16.
- R2: `sel_high_i`=0 inverts `pin_drive_o` relative to `sel_high_i`=1, in both registered and combinational mode.
- R3: With `sel_comb_i`=0, the flip-flop captures the OR sum on each rising edge of `clk_i`. `pin_drive_o` does not change between edges, even when `terms_i` changes. Active-high gives `pin_drive_o` = state; active-low gives `pin_drive_o` = NOT state.
- R4: With `sel_comb_i`=0, `fb_o` equals the inverted flip-flop state. This holds whatever the polarity and whatever the level of `oe_term_i`.
- R5: With `sel_comb_i`=1, `fb_o` equals `pin_drive_o` when the driver is enabled, and `pin_ext_i` when it is disabled.
- R6: `pin_en_o` equals `oe_term_i` in both modes. A 0 means the pin is high-impedance.
- R7: `areset_term_i`=1 clears the flip-flop at once, without a clock edge.
- R8: `spreset_term_i`=1 sets the flip-flop to 1 at the next rising edge, whatever the OR sum is.
- R9: When `areset_term_i` and `spreset_term_i` are both 1, the flip-flop stays cleared.
- R10: In combinational mode the flip-flop keeps capturing the sum on each edge. Its state has no effect on the pin or on `fb_o` until registered mode is selected again, and then it shows at once.
- R11: While `rst_ni`=0, the flip-flop is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Global clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| terms_i | input | N_TERMS | Product terms that feed the OR gate |
| oe_term_i | input | 1 | Output-enable product term |
| areset_term_i | input | 1 | Global asynchronous clear term |
| spreset_term_i | input | 1 | Global synchronous set term |
| sel_comb_i | input | 1 | 1 = combinational, 0 = registered |
| sel_high_i | input | 1 | 1 = active-high, 0 = active-low |
| pin_ext_i | input | 1 | Level driven onto the pin from outside |
| pin_drive_o | output | 1 | Value the cell drives onto the pin |
| pin_en_o | output | 1 | Pin driver enable; 0 = high-impedance |
| fb_o | output | 1 | Feedback to the logic plane |

## Verification
The only state in the cell is one flip-flop. In registered mode a wrong value in it shows on `pin_drive_o` and on `fb_o` in the same cycle, with opposite senses. A wrong clear or set priority shows at the first edge after both global terms are raised together. A flip-flop that stopped clocking during combinational mode is hidden until registered mode is selected again. It then shows at once, so the bench switches modes between edges to expose it.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  localparam int unsigned MIN_TERMS = 8;
  localparam int unsigned MAX_TERMS = 16;

  // {sel_comb, sel_high}
  typedef enum logic [1:0] {
    MODE_REG_LO = 2'b00,
    MODE_REG_HI = 2'b01,
    MODE_CMB_LO = 2'b10,
    MODE_CMB_HI = 2'b11
  } mcell_mode_e;
endpackage

// File: rtl/mcell_term_sum.sv
module mcell_term_sum #(
  parameter int unsigned N_TERMS = 8
) (
  input  logic [N_TERMS-1:0] terms_i,
  output logic               sum_o
);
  logic [N_TERMS:0] chain;
  assign chain[0] = 1'b0;
  for (genvar g = 0; g < N_TERMS; g++) begin : g_or
    assign chain[g+1] = chain[g] | terms_i[g];
  end
  assign sum_o = chain[N_TERMS];
endmodule

// File: rtl/mcell_state_reg.sv
module mcell_state_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic aclr_i,
  input  logic sset_i,
  input  logic d_i,
  output logic q_o,
  output logic qn_o
);
  logic clr_n;
  logic q;

  // The global clear term joins the chip reset as an asynchronous clear.
  assign clr_n = rst_ni & ~aclr_i;

  always_ff @(posedge clk_i or negedge clr_n) begin
    if (!clr_n) q <= 1'b0;
    else        q <= sset_i | d_i;
  end

  assign q_o  = q;
  assign qn_o = ~q;
endmodule

// File: rtl/mcell_out_path.sv
module mcell_out_path
  import mcell_pkg::*;
(
  input  mcell_mode_e mode_i,
  input  logic        sum_i,
  input  logic        q_i,
  input  logic        qn_i,
  input  logic        oe_i,
  input  logic        pin_ext_i,
  output logic        drive_o,
  output logic        en_o,
  output logic        fb_o
);
  logic pin_level;

  always_comb begin
    unique case (mode_i)
      MODE_REG_LO: drive_o = qn_i;
      MODE_REG_HI: drive_o = q_i;
      MODE_CMB_LO: drive_o = ~sum_i;
      default:     drive_o = sum_i;
    endcase
  end

  assign en_o      = oe_i;
  assign pin_level = oe_i ? drive_o : pin_ext_i;

  always_comb begin
    unique case (mode_i)
      MODE_REG_LO, MODE_REG_HI: fb_o = qn_i;
      default:                  fb_o = pin_level;
    endcase
  end
endmodule

// File: rtl/out_macrocell.sv
module out_macrocell
  import mcell_pkg::*;
#(
  parameter int unsigned N_TERMS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_TERMS-1:0] terms_i,
  input  logic               oe_term_i,
  input  logic               areset_term_i,
  input  logic               spreset_term_i,
  input  logic               sel_comb_i,
  input  logic               sel_high_i,
  input  logic               pin_ext_i,
  output logic               pin_drive_o,
  output logic               pin_en_o,
  output logic               fb_o
);
  mcell_mode_e mode;
  logic        sum;
  logic        q;
  logic        qn;

  assign mode = mcell_mode_e'({sel_comb_i, sel_high_i});

  mcell_term_sum #(.N_TERMS(N_TERMS)) u_sum (
    .terms_i (terms_i),
    .sum_o   (sum)
  );

  mcell_state_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .aclr_i (areset_term_i),
    .sset_i (spreset_term_i),
    .d_i    (sum),
    .q_o    (q),
    .qn_o   (qn)
  );

  mcell_out_path u_out (
    .mode_i    (mode),
    .sum_i     (sum),
    .q_i       (q),
    .qn_i      (qn),
    .oe_i      (oe_term_i),
    .pin_ext_i (pin_ext_i),
    .drive_o   (pin_drive_o),
    .en_o      (pin_en_o),
    .fb_o      (fb_o)
  );
endmodule

// File: rtl/out_macrocell_chk.sv
module out_macrocell_chk #(
  parameter int unsigned N_TERMS = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_TERMS-1:0] terms_i,
  input logic               oe_term_i,
  input logic               areset_term_i,
  input logic               spreset_term_i,
  input logic               sel_comb_i,
  input logic               sel_high_i,
  input logic               pin_ext_i,
  input logic               pin_drive_o,
  input logic               pin_en_o,
  input logic               fb_o
);
  a_r6_enable_follows_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_en_o == oe_term_i);

  a_r2_comb_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_comb_i |-> pin_drive_o == ((|terms_i) ~^ sel_high_i));

  a_r5_comb_fb_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_comb_i && !oe_term_i) |-> fb_o == pin_ext_i);

  a_r5_comb_fb_drv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_comb_i && oe_term_i) |-> fb_o == pin_drive_o);

  a_r7_clear_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (areset_term_i && !sel_comb_i) |-> fb_o);

  a_r3_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!spreset_term_i && !areset_term_i) |=>
      (sel_comb_i || areset_term_i || fb_o == !(|$past(terms_i))));

  a_r8_set_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spreset_term_i && !areset_term_i) |=> (sel_comb_i || areset_term_i || !fb_o));

  a_r4_reg_fb_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_comb_i |-> fb_o == (sel_high_i ? !pin_drive_o : pin_drive_o));
endmodule

bind out_macrocell out_macrocell_chk #(.N_TERMS(N_TERMS)) u_chk (.*);

// File: tb/sim_out_macrocell.sv
`timescale 1ns/1ps
module sim_out_macrocell;
  localparam int unsigned NT = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NT-1:0] terms_i = '0;
  logic          oe_term_i = 1'b1;
  logic          areset_term_i = 1'b0;
  logic          spreset_term_i = 1'b0;
  logic          sel_comb_i = 1'b0;
  logic          sel_high_i = 1'b1;
  logic          pin_ext_i = 1'b0;
  logic          pin_drive_o, pin_en_o, fb_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  out_macrocell #(.N_TERMS(NT)) u0 (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Change inputs just after a falling edge; sample 1 ns later.
  task automatic settle();
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk_i); settle();
    chk("R11 pin during reset", pin_drive_o, 1'b0);
    chk("R11 fb during reset", fb_o, 1'b1);
    @(negedge clk_i); rst_ni = 1'b1; settle();
    chk("R11 pin after reset", pin_drive_o, 1'b0);
  endtask

  task automatic t_comb_patterns();
    @(negedge clk_i);
    sel_comb_i = 1'b1; sel_high_i = 1'b1; terms_i = '0; settle();
    chk("R1 all zero", pin_drive_o, 1'b0);
    for (int i = 0; i < NT; i++) begin
      terms_i = '0; terms_i[i] = 1'b1; settle();
      chk("R1 single term", pin_drive_o, 1'b1);
    end
    terms_i = '1; settle();
    chk("R1 all ones", pin_drive_o, 1'b1);
    sel_high_i = 1'b0; settle();
    chk("R2 comb active-low ones", pin_drive_o, 1'b0);
    terms_i = '0; settle();
    chk("R2 comb active-low zero", pin_drive_o, 1'b1);
  endtask

  task automatic t_registered();
    @(negedge clk_i);
    sel_comb_i = 1'b0; sel_high_i = 1'b1; terms_i = '0;
    @(negedge clk_i);
    terms_i[3] = 1'b1; settle();
    chk("R3 no change before edge", pin_drive_o, 1'b0);
    @(negedge clk_i); settle();
    chk("R3 captured high", pin_drive_o, 1'b1);
    chk("R4 fb inverted q", fb_o, 1'b0);
    terms_i = '0; settle();
    chk("R3 stable between edges", pin_drive_o, 1'b1);
    sel_high_i = 1'b0; settle();
    chk("R2 reg active-low", pin_drive_o, 1'b0);
    chk("R4 fb unaffected by polarity", fb_o, 1'b0);
    oe_term_i = 1'b0; pin_ext_i = 1'b1; settle();
    chk("R4 fb ignores oe", fb_o, 1'b0);
    oe_term_i = 1'b1; pin_ext_i = 1'b0;
    @(negedge clk_i); settle();
    chk("R3 captured low", pin_drive_o, 1'b1);
    chk("R4 fb after low", fb_o, 1'b1);
    sel_high_i = 1'b1;
  endtask

  task automatic t_comb_feedback_oe();
    @(negedge clk_i);
    sel_comb_i = 1'b1; sel_high_i = 1'b1; terms_i = 'b100; oe_term_i = 1'b1; settle();
    chk("R6 enabled", pin_en_o, 1'b1);
    chk("R5 fb driven", fb_o, 1'b1);
    oe_term_i = 1'b0; pin_ext_i = 1'b0; settle();
    chk("R6 hi-z", pin_en_o, 1'b0);
    chk("R5 fb ext low", fb_o, 1'b0);
    pin_ext_i = 1'b1; terms_i = '0; settle();
    chk("R5 fb ext high", fb_o, 1'b1);
    sel_comb_i = 1'b0; settle();
    chk("R6 hi-z registered", pin_en_o, 1'b0);
    oe_term_i = 1'b1; pin_ext_i = 1'b0;
  endtask

  task automatic t_global_terms();
    @(negedge clk_i);
    sel_comb_i = 1'b0; sel_high_i = 1'b1; terms_i = '1;
    @(negedge clk_i); settle();
    chk("R3 set up high", pin_drive_o, 1'b1);
    areset_term_i = 1'b1; settle();
    chk("R7 clear without edge", pin_drive_o, 1'b0);
    chk("R7 fb after clear", fb_o, 1'b1);
    @(negedge clk_i); settle();
    chk("R7 clear holds over edge", pin_drive_o, 1'b0);
    areset_term_i = 1'b0; terms_i = '0; spreset_term_i = 1'b1; settle();
    chk("R8 no set before edge", pin_drive_o, 1'b0);
    @(negedge clk_i); settle();
    chk("R8 set at edge", pin_drive_o, 1'b1);
    spreset_term_i = 1'b0;
    @(negedge clk_i); settle();
    chk("R8 released follows sum", pin_drive_o, 1'b0);
    areset_term_i = 1'b1; spreset_term_i = 1'b1;
    @(negedge clk_i); settle();
    chk("R9 clear beats set", pin_drive_o, 1'b0);
    areset_term_i = 1'b0; spreset_term_i = 1'b0;
  endtask

  task automatic t_flop_in_comb();
    @(negedge clk_i);
    sel_comb_i = 1'b1; sel_high_i = 1'b1; terms_i = '0;
    @(negedge clk_i);
    terms_i = 'b1;
    @(negedge clk_i);
    terms_i = '0; settle();
    chk("R10 comb pin ignores flop", pin_drive_o, 1'b0);
    sel_comb_i = 1'b0; settle();
    chk("R10 flop kept clocking", pin_drive_o, 1'b1);
    chk("R10 fb from flop", fb_o, 1'b0);
  endtask

  initial begin
    t_reset();
    t_comb_patterns();
    t_registered();
    t_comb_feedback_oe();
    t_global_terms();
    t_flop_in_comb();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule